// File: doc/BRIEF.md
# Square-Root Carry Select Adder with Increment-Based Upper Path

This block adds two 128-bit operands and a carry-in and returns a 128-bit sum with a carry-out. It is purely combinational. The word is cut into sixteen slices whose widths grow toward the most significant end, so the carry select delay is balanced across the word. The bottom slice is a plain ripple adder fed by the external carry-in.

Every other slice computes one ripple-carry result with its carry-in forced to zero. Its sum bits and carry-out are then passed through an incrementer to give the carry-in-equals-one result, so no second adder is needed. Both candidates are ready before the slice's incoming carry arrives. A word-wide 2:1 multiplexer, steered by that carry, picks one of them. The top bit of the picked word is the carry into the next slice.

The block sits inside a larger datapath that provides timing around it.

Top module: `csa_sqrt_add`

## Requirements
- R1: For every operand pair and carry-in, {cout_o, sum_o} equals opa_i + opb_i + cin_i taken as a 129-bit unsigned value.
- R2: The lowest slice covers bits 1:0. It is a ripple adder using cin_i directly, so sum_o[1:0] equals the low two bits of opa_i[1:0] + opb_i[1:0] + cin_i.
- R3: In each upper slice, the incrementer output equals its (n+1)-bit input plus one, modulo 2^(n+1). Bit 0 is the inverse of input bit 0. Each higher bit is the input bit XOR the AND of all lower input bits.
- R4: When a slice's incoming carry is 0, the slice outputs its carry-zero result unchanged.
- R5: When a slice's incoming carry is 1, the slice outputs the incremented result.
- R6: Slice widths from the least significant end are 2,2,3,4,5,6,7,8,9,10,11,12,12,12,12,13, which puts slice boundaries at bits 2,4,7,11,16,22,29,37,46,56,67,79,91,103,115. A carry generated below any boundary reaches the bit at that boundary.
- R7: cout_o is the carry out of the top slice. Adding 2^127 to 2^127 gives cout_o = 1 and sum_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 128 | First operand |
| opb_i | input | 128 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 128 | Sum bits |
| cout_o | output | 1 | Carry out of bit 127 |

## Verification
The checks inside the slices compare against arithmetic reference sums, so they assume fully known (0/1) inputs. They stay silent while any input is unknown, which covers the time before the bench first drives the ports. The bench always drives every operand bit and the carry-in with defined values. Its vectors are built to make the carry enter each slice both at 0 and at 1, and to ripple across every slice boundary.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int unsigned ADD_W   = 128;
  localparam int unsigned NUM_GRP = 16;

  function automatic int unsigned grp_width(input int unsigned k);
    case (k)
      0, 1:          return 2;
      12, 13, 14:    return 12;
      15:            return 13;
      default:       return k + 1;
    endcase
  endfunction

  function automatic int unsigned grp_lsb(input int unsigned k);
    int unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j < k; j++) acc += grp_width(j);
    return acc;
  endfunction
endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         c_i,
  output logic [N-1:0] s_o,
  output logic         c_o
);
  logic [N:0] cy;
  assign cy[0] = c_i;

  for (genvar i = 0; i < N; i++) begin : g_fa
    assign s_o[i]  = a_i[i] ^ b_i[i] ^ cy[i];
    assign cy[i+1] = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
  end

  assign c_o = cy[N];

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i}))
      AST_RIPPLE_SUM: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, c_i})); // R2
  end
endmodule

// File: rtl/csa_excess1.sv
module csa_excess1 #(
  parameter int unsigned M = 5
) (
  input  logic [M-1:0] bin_i,
  output logic [M-1:0] inc_o
);
  logic [M:0] all_low;
  assign all_low[0] = 1'b1;

  for (genvar i = 0; i < M; i++) begin : g_bit
    assign inc_o[i]     = bin_i[i] ^ all_low[i];
    assign all_low[i+1] = all_low[i] & bin_i[i];
  end

  always_comb begin
    if (!$isunknown(bin_i))
      AST_EXCESS_ONE: assert (inc_o == M'(bin_i + 1'b1)); // R3
  end
endmodule

// File: rtl/csa_group.sv
module csa_group #(
  parameter int unsigned N      = 4,
  parameter bit          SELECT = 1'b1
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         c_i,
  output logic [N-1:0] s_o,
  output logic         c_o
);
  localparam int unsigned WW = N + 1;

  if (SELECT) begin : g_sel
    logic [N-1:0]  raw_s;
    logic          raw_c;
    logic [WW-1:0] zero_w;
    logic [WW-1:0] one_w;
    logic [WW-1:0] pick_w;

    csa_ripple #(.N(N)) u_rca (
      .a_i(a_i), .b_i(b_i), .c_i(1'b0), .s_o(raw_s), .c_o(raw_c)
    );

    assign zero_w = {raw_c, raw_s};

    csa_excess1 #(.M(WW)) u_inc (
      .bin_i(zero_w), .inc_o(one_w)
    );

    always_comb begin
      pick_w = c_i ? one_w : zero_w;
    end

    assign s_o = pick_w[N-1:0];
    assign c_o = pick_w[N];

    always_comb begin
      if (!$isunknown({a_i, b_i, c_i})) begin
        if (!c_i)
          AST_SEL_ZERO: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i})); // R4
        else
          AST_SEL_ONE: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + WW'(1))); // R5
      end
    end
  end else begin : g_plain
    csa_ripple #(.N(N)) u_rca (
      .a_i(a_i), .b_i(b_i), .c_i(c_i), .s_o(s_o), .c_o(c_o)
    );
  end
endmodule

// File: rtl/csa_sqrt_add.sv
module csa_sqrt_add
  import csa_pkg::*;
(
  input  logic [ADD_W-1:0] opa_i,
  input  logic [ADD_W-1:0] opb_i,
  input  logic             cin_i,
  output logic [ADD_W-1:0] sum_o,
  output logic             cout_o
);
  logic [NUM_GRP:0] gcy;
  assign gcy[0] = cin_i;

  for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
    localparam int unsigned GW = grp_width(k);
    localparam int unsigned LO = grp_lsb(k);

    csa_group #(.N(GW), .SELECT(k != 0)) u_grp (
      .a_i(opa_i[LO +: GW]),
      .b_i(opb_i[LO +: GW]),
      .c_i(gcy[k]),
      .s_o(sum_o[LO +: GW]),
      .c_o(gcy[k+1])
    );
  end

  assign cout_o = gcy[NUM_GRP];

  always_comb begin
    if (!$isunknown({opa_i, opb_i, cin_i}))
      AST_TOTAL_SUM: assert ({cout_o, sum_o} == ({1'b0, opa_i} + {1'b0, opb_i} + {{ADD_W{1'b0}}, cin_i})); // R1
  end
endmodule

// File: tb/sim_csa_sqrt_add.sv
module sim_csa_sqrt_add;
  localparam int W = 128;

  logic clk;
  logic [W-1:0] opa, opb, sum;
  logic cin, cout;
  int n_vec, n_bad, cyc;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  csa_sqrt_add u0 (
    .opa_i(opa), .opb_i(opb), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, input string req);
    logic [W:0] exp_v;
    @(posedge clk);
    opa = a; opb = b; cin = c;
    exp_v = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    @(negedge clk);
    n_vec++;
    if ({cout, sum} !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, {cout, sum}, exp_v);
    end
  endtask

  function automatic logic [W-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int lsb [16] = '{0,2,4,7,11,16,22,29,37,46,56,67,79,91,103,115};
    n_vec = 0; n_bad = 0;
    opa = '0; opb = '0; cin = 1'b0;

    apply('0, '0, 1'b0, "R1 zero plus zero");
    apply('0, '0, 1'b1, "R1 zero plus carry");
    apply({W{1'b1}}, '0, 1'b1, "R6 full ripple all-ones plus 1");
    apply({W{1'b1}}, 128'd1, 1'b0, "R1 all-ones plus one");
    apply({W{1'b1}}, {W{1'b1}}, 1'b1, "R1 max plus max plus 1");
    apply({64{2'b10}}, {64{2'b01}}, 1'b0, "R4 alternating no carry");
    apply({64{2'b10}}, {64{2'b01}}, 1'b1, "R5 alternating with carry");
    apply({64{2'b10}}, {64{2'b10}}, 1'b1, "R1 alternating doubled");
    apply(128'd1 << 127, 128'd1 << 127, 1'b0, "R7 top carry out");

    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 2; c++)
          apply(W'(a), W'(b), c[0], "R2 low slice sweep");

    for (int k = 1; k < 16; k++) begin
      logic [W-1:0] below;
      below = (128'd1 << lsb[k]) - 128'd1;
      apply(below, '0, 1'b1, "R6 carry into boundary");
      apply(below, '0, 1'b0, "R4 boundary carry held 0");
      apply(128'd1 << (lsb[k] - 1), 128'd1 << (lsb[k] - 1), 1'b0, "R5 generate at boundary");
      apply({W{1'b1}} << lsb[k], below, 1'b1, "R3 increment wraps slice");
    end

    for (int i = 0; i < 2000; i++) begin
      logic [W-1:0] ra, rb;
      ra = rnd128(); rb = rnd128();
      apply(ra, rb, 1'b0, "R1 random cin0");
      apply(ra, rb, 1'b1, "R1 random cin1");
      apply(ra, ~ra, 1'b1, "R5 random complement");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule